// File: doc/BRIEF.md
# Selectable Cache Replacement Engine

This block holds the replacement bookkeeping for every set of a k-way set-associative cache and names the way to overwrite when the cache controller reports a miss. Three policies share one set of per-set state: exact recency order (LRU), a round-robin insertion pointer (FIFO) and a pseudo-random pick from a linear feedback shift register. The policy is chosen on every access through a two-bit select input, so a controller can switch policy at run time without losing state.

Each cycle the controller presents a set index. It may raise a hit flag with the way that hit, a fill strobe for a miss, or both together. One cycle after a fill strobe the engine returns the chosen way with a valid strobe. Tag and data arrays, the refill path and the write policy sit outside this block.

Top module: `repl_engine`

## Requirements
- R1: After reset is released, `victim_vld` is low and `victim_way` is 0 until the first fill request arrives.
- R2: While a set still has ways that have never been filled, a fill picks the lowest-numbered unfilled way, whatever the policy. After reset every way of every set counts as unfilled.
- R3: `victim_vld` is high in exactly the cycle after a cycle with `fill_req` high. `victim_way` changes only in that cycle and otherwise keeps its last value.
- R4: With `pol_sel` = 2'b00 (LRU) and a full set, the victim is the way whose latest use (hit or fill) is oldest. After reset, each set's recency order, from newest to oldest, is way 0 first and way k-1 last.
- R5: In LRU mode a hit makes the hit way the most recently used way of its set. A fill does the same for the way it returns.
- R6: With `pol_sel` = 2'b01 (FIFO) and a full set, the victim is the set's round-robin pointer. The pointer starts at 0, steps by one modulo k on every fill into that set, and is not moved by hits.
- R7: For fills with no hits in between, FIFO and LRU return the same sequence of ways.
- R8: With `pol_sel` = 2'b10 (random) and a full set, the victim is the low log2(k) bits of an 8-bit LFSR. The LFSR is seeded 8'h5A at reset. On every fill in any set and any mode it steps to {s[6:0], s[7]^s[5]^s[4]^s[3]}. The victim uses the value held before the step.
- R9: When a hit and a fill reach the same set in the same cycle, the hit's reordering is applied first. The victim is then chosen from the reordered state.
- R10: Hits and fills change only the state of the set named by `acc_set`. Other sets keep their state.
- R11: `pol_sel` = 2'b11 selects LRU as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pol_sel | input | 2 | Policy: 00 LRU, 01 FIFO, 10 random, 11 LRU |
| acc_set | input | SET_W | Set addressed by this cycle's hit and/or fill |
| hit_vld | input | 1 | A lookup in `acc_set` hit |
| hit_way | input | WAY_W | Way that hit |
| fill_req | input | 1 | A miss in `acc_set` needs a victim |
| victim_way | output | WAY_W | Chosen way, registered |
| victim_vld | output | 1 | `victim_way` holds a new choice this cycle |

## Verification
A hit and a fill addressed to the same set can fall in the same cycle, and their order decides the victim. The bench fills a set until it is full, which leaves its LRU order newest-to-oldest as 3,2,1,0. It then drives a hit on way 0 in the same cycle as a fill. Hit-first ordering yields way 1, while fill-first ordering would give way 0. A following plain fill must then return way 2, which confirms that both updates reached the stored order.

// File: rtl/repl_pkg.sv
package repl_pkg;
   typedef enum logic [1:0] {
      POL_LRU  = 2'b00,
      POL_FIFO = 2'b01,
      POL_RAND = 2'b10,
      POL_LRU2 = 2'b11
   } pol_e;
endpackage

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
   parameter int W = 8,
   parameter logic [W-1:0] TAPS = 8'hB8,
   parameter logic [W-1:0] SEED = 8'h5A,
   parameter int OUT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [OUT_W-1:0] low_bits
);
   if (OUT_W > W) begin : g_bad_out
      $error("repl_lfsr: OUT_W exceeds register width");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("repl_lfsr: seed must be nonzero");
   end

   logic [W-1:0] state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state <= SEED;
      else if (step) state <= {state[W-2:0], ^(state & TAPS)};
   end

   assign low_bits = state[OUT_W-1:0];
endmodule

// File: rtl/repl_lru_set.sv
module repl_lru_set #(
   parameter int NUM_WAYS = 4,
   localparam int WAY_W = $clog2(NUM_WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_en,
   input  logic [WAY_W-1:0] hit_way,
   input  logic             fill_en,
   input  logic [WAY_W-1:0] fill_way,
   output logic [WAY_W-1:0] oldest_way
);
   typedef logic [NUM_WAYS-1:0][WAY_W-1:0] order_t;

   order_t order_q, order_hit, order_nxt;

   function automatic order_t to_front(input order_t q, input logic [WAY_W-1:0] w);
      order_t r;
      int pos;
      pos = NUM_WAYS - 1;
      for (int i = 0; i < NUM_WAYS; i++) begin
         if (q[i] == w) pos = i;
      end
      for (int i = 0; i < NUM_WAYS; i++) begin
         if (i == 0)        r[i] = w;
         else if (i <= pos) r[i] = q[i-1];
         else               r[i] = q[i];
      end
      return r;
   endfunction

   always_comb begin
      order_hit = hit_en  ? to_front(order_q, hit_way)    : order_q;
      order_nxt = fill_en ? to_front(order_hit, fill_way) : order_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WAYS; i++) order_q[i] <= WAY_W'(i);
      end else begin
         order_q <= order_nxt;
      end
   end

   assign oldest_way = order_hit[NUM_WAYS-1];
endmodule

// File: rtl/repl_rr_set.sv
module repl_rr_set #(
   parameter int NUM_WAYS = 4,
   localparam int WAY_W = $clog2(NUM_WAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fill_en,
   input  logic [WAY_W-1:0]    fill_way,
   output logic [WAY_W-1:0]    rr_ptr,
   output logic [NUM_WAYS-1:0] filled
);
   logic [WAY_W-1:0] ptr_nxt;

   if ((NUM_WAYS & (NUM_WAYS - 1)) == 0) begin : g_pow2
      assign ptr_nxt = rr_ptr + 1'b1;
   end else begin : g_wrap
      assign ptr_nxt = (rr_ptr == WAY_W'(NUM_WAYS - 1)) ? '0 : rr_ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_ptr <= '0;
         filled <= '0;
      end else if (fill_en) begin
         rr_ptr           <= ptr_nxt;
         filled[fill_way] <= 1'b1;
      end
   end
endmodule

// File: rtl/repl_engine.sv
module repl_engine #(
   parameter int NUM_SETS = 8,
   parameter int NUM_WAYS = 4,
   parameter int LFSR_W = 8,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h5A,
   localparam int SET_W = $clog2(NUM_SETS),
   localparam int WAY_W = $clog2(NUM_WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       pol_sel,
   input  logic [SET_W-1:0] acc_set,
   input  logic             hit_vld,
   input  logic [WAY_W-1:0] hit_way,
   input  logic             fill_req,
   output logic [WAY_W-1:0] victim_way,
   output logic             victim_vld
);
   import repl_pkg::*;

   if (NUM_WAYS < 2 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
      $error("repl_engine: NUM_WAYS must be a power of two >= 2");
   end
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("repl_engine: NUM_SETS must be a power of two >= 2");
   end
   if (LFSR_W < WAY_W + 2) begin : g_bad_lfsr
      $error("repl_engine: LFSR too narrow for the way count");
   end

   logic [WAY_W-1:0]    oldest_arr [NUM_SETS];
   logic [WAY_W-1:0]    ptr_arr    [NUM_SETS];
   logic [NUM_WAYS-1:0] filled_arr [NUM_SETS];
   logic [WAY_W-1:0]    rnd_way;
   logic [WAY_W-1:0]    pick;
   logic [NUM_WAYS-1:0] sel_filled;

   function automatic logic [WAY_W-1:0] lowest_free(input logic [NUM_WAYS-1:0] f);
      logic [WAY_W-1:0] r;
      r = '0;
      for (int i = NUM_WAYS - 1; i >= 0; i--) begin
         if (!f[i]) r = WAY_W'(i);
      end
      return r;
   endfunction

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      logic here;
      assign here = (acc_set == SET_W'(s));

      repl_lru_set #(.NUM_WAYS(NUM_WAYS)) u_lru (
         .clk        (clk),
         .rst_n      (rst_n),
         .hit_en     (hit_vld && here),
         .hit_way    (hit_way),
         .fill_en    (fill_req && here),
         .fill_way   (pick),
         .oldest_way (oldest_arr[s])
      );

      repl_rr_set #(.NUM_WAYS(NUM_WAYS)) u_rr (
         .clk      (clk),
         .rst_n    (rst_n),
         .fill_en  (fill_req && here),
         .fill_way (pick),
         .rr_ptr   (ptr_arr[s]),
         .filled   (filled_arr[s])
      );
   end

   repl_lfsr #(
      .W     (LFSR_W),
      .TAPS  (LFSR_TAPS),
      .SEED  (LFSR_SEED),
      .OUT_W (WAY_W)
   ) u_lfsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (fill_req),
      .low_bits (rnd_way)
   );

   assign sel_filled = filled_arr[acc_set];

   always_comb begin
      if (!(&sel_filled)) begin
         pick = lowest_free(sel_filled);
      end else begin
         unique case (pol_e'(pol_sel))
            POL_FIFO: pick = ptr_arr[acc_set];
            POL_RAND: pick = rnd_way;
            default:  pick = oldest_arr[acc_set];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         victim_vld <= 1'b0;
         victim_way <= '0;
      end else begin
         victim_vld <= fill_req;
         if (fill_req) victim_way <= pick;
      end
   end
endmodule

// File: rtl/repl_engine_chk.sv
module repl_engine_chk #(
   parameter int NUM_SETS = 8,
   parameter int NUM_WAYS = 4,
   localparam int SET_W = $clog2(NUM_SETS),
   localparam int WAY_W = $clog2(NUM_WAYS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       pol_sel,
   input logic [SET_W-1:0] acc_set,
   input logic             hit_vld,
   input logic             fill_req,
   input logic [WAY_W-1:0] victim_way,
   input logic             victim_vld
);
   localparam logic [WAY_W:0] WAYS_C = (WAY_W + 1)'(NUM_WAYS);

   logic [WAY_W:0]   fills_seen [NUM_SETS];
   logic             exp_free;
   logic [WAY_W-1:0] exp_way;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) fills_seen[s] <= '0;
         exp_free <= 1'b0;
         exp_way  <= '0;
      end else begin
         exp_free <= fill_req && (fills_seen[acc_set] < WAYS_C);
         exp_way  <= fills_seen[acc_set][WAY_W-1:0];
         if (fill_req && fills_seen[acc_set] < WAYS_C)
            fills_seen[acc_set] <= fills_seen[acc_set] + 1'b1;
      end
   end

   p_vld_after_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |=> victim_vld);

   p_no_vld_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_req |=> !victim_vld);

   p_way_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_req |=> $stable(victim_way));

   p_free_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      exp_free |-> (victim_way == exp_way));

   p_no_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && $past(fill_req) && acc_set == $past(acc_set) && !hit_vld &&
       pol_sel != 2'b10 && pol_sel == $past(pol_sel))
      |=> (victim_way != $past(victim_way)));
endmodule

bind repl_engine repl_engine_chk #(
   .NUM_SETS (NUM_SETS),
   .NUM_WAYS (NUM_WAYS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pol_sel    (pol_sel),
   .acc_set    (acc_set),
   .hit_vld    (hit_vld),
   .fill_req   (fill_req),
   .victim_way (victim_way),
   .victim_vld (victim_vld)
);

// File: tb/repl_engine_test.sv
`timescale 1ns/1ps
module repl_engine_test;
   localparam logic [1:0] LRU = 2'b00, FIFO = 2'b01, RND = 2'b10, LRU2 = 2'b11;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pol_sel = 2'b00;
   logic [2:0] acc_set = '0;
   logic       hit_vld = 1'b0;
   logic [1:0] hit_way = '0;
   logic       fill_req = 1'b0;
   logic [1:0] victim_way;
   logic       victim_vld;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done = 0;
   logic [7:0] lf = 8'h5A;
   logic [1:0] got_way;
   logic       got_vld;

   always #10 clk = ~clk;

   repl_engine uut (
      .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .acc_set(acc_set),
      .hit_vld(hit_vld), .hit_way(hit_way), .fill_req(fill_req),
      .victim_way(victim_way), .victim_vld(victim_vld)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic op(input logic [1:0] pol, input int set, input logic hv,
                     input int hw, input logic fv);
      @(negedge clk);
      pol_sel = pol; acc_set = 3'(set); hit_vld = hv; hit_way = 2'(hw); fill_req = fv;
      @(negedge clk);
      hit_vld = 1'b0; fill_req = 1'b0;
      got_vld = victim_vld; got_way = victim_way;
      if (fv) lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
   endtask

   task automatic fill_exp(input string req, input logic [1:0] pol, input int set, input int exp);
      op(pol, set, 1'b0, 0, 1'b1);
      check({req, " vld"}, got_vld, 1);
      check({req, " way"}, got_way, exp);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      lf = 8'h5A;
      @(negedge clk);
      check("R1 vld", victim_vld, 0);
      check("R1 way", victim_way, 0);
   endtask

   task automatic t_free_first;
      for (int w = 0; w < 4; w++) fill_exp("R2 lru", LRU, 2, w);
      for (int w = 0; w < 4; w++) fill_exp("R2 rnd", RND, 6, w);
   endtask

   task automatic t_lru;
      // set 2 order newest..oldest: 3,2,1,0
      op(LRU, 2, 1'b1, 1, 1'b0);
      check("R3 no vld on hit", got_vld, 0);
      check("R3 way held", got_way, 3);
      fill_exp("R5 hit moved", LRU, 2, 0);      // 0,1,3,2
      op(LRU, 2, 1'b1, 2, 1'b0);                // 2,0,1,3
      fill_exp("R5 hit from tail", LRU, 2, 3);  // 3,2,0,1
      fill_exp("R4 oldest", LRU, 2, 1);
   endtask

   task automatic t_fifo;
      for (int w = 0; w < 4; w++) fill_exp("R6 fill", FIFO, 3, w);
      op(FIFO, 3, 1'b1, 0, 1'b0);
      fill_exp("R6 hit ignored", FIFO, 3, 0);
      op(FIFO, 3, 1'b1, 1, 1'b0);
      fill_exp("R6 ptr step", FIFO, 3, 1);
      fill_exp("R6 ptr step2", FIFO, 3, 2);
   endtask

   task automatic t_same_order;
      for (int r = 0; r < 2; r++)
         for (int w = 0; w < 4; w++) fill_exp("R7 lru", LRU, 4, w);
      for (int r = 0; r < 2; r++)
         for (int w = 0; w < 4; w++) fill_exp("R7 fifo", FIFO, 5, w);
   endtask

   task automatic t_random;
      for (int i = 0; i < 6; i++) fill_exp("R8 lfsr", RND, 6, int'(lf[1:0]));
   endtask

   task automatic t_collide;
      for (int w = 0; w < 4; w++) fill_exp("R9 prep", LRU, 7, w);
      op(LRU, 7, 1'b1, 0, 1'b1);
      check("R9 hit first vld", got_vld, 1);
      check("R9 hit first way", got_way, 1);   // order now 1,0,3,2
      fill_exp("R9 after", LRU, 7, 2);
   endtask

   task automatic t_alt_code;
      for (int w = 0; w < 4; w++) fill_exp("R11 prep", LRU2, 1, w);
      op(LRU2, 1, 1'b1, 0, 1'b0);
      fill_exp("R11 lru", LRU2, 1, 1);
   endtask

   task automatic t_isolation;
      fill_exp("R10 set0 untouched", FIFO, 0, 0);
      repeat (2) @(negedge clk);
      check("R3 idle vld", victim_vld, 0);
      check("R3 idle hold", victim_way, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_free_first();
      t_lru();
      t_fifo();
      t_same_order();
      t_random();
      t_collide();
      t_alt_code();
      t_isolation();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule